// File: doc/BRIEF.md
# I2C Target Address Matcher

This block sits next to the receive shifter of an I2C target. After a START, the bus logic has the address byte and, in 10-bit mode, a second byte. It pulses a compare strobe. In the next clock edge the matcher decides whether the device must acknowledge. It also reports which address source won and which address was recognised.

There are five candidate sources:
- a primary own address, 10 bits wide, matched either as a 7-bit address or as a two-byte 10-bit address;
- a secondary 7-bit address with a per-bit don't-care mask;
- the general call address;
- the SMBus default device address;
- the SMBus alert response address.

Each source has its own enable. When more than one source recognises the same byte, a fixed priority picks the winner. The results stay registered until the next strobe, so the bus state machine and status logic can read them at leisure. The register that feeds `own_en` should reset to 1 and the one feeding `alt_en` to 0. The package records these values for that register's owner.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: While `rst` is high and after it, until the first strobe, `match`, `ack`, `alt_hit`, `gcall_hit` are 0 and `match_addr` is 0.
- R2: With `own_en`=1 and `own_ten_bit`=0, the primary source hits when `rx_first[7:1]` equals `own_addr[6:0]`. `own_addr[9:7]`, `rx_first[0]` (read/write bit) and `rx_second` take no part.
- R3: With `own_en`=1 and `own_ten_bit`=1, the primary source hits only when all three of these hold: `rx_first[7:3]`=5'b11110, `rx_first[2:1]`=`own_addr[9:8]`, and `rx_second`=`own_addr[7:0]`. In this mode a 7-bit compare against `own_addr[6:0]` never hits.
- R4: With `alt_en`=1, the secondary source hits when every bit `i` of `rx_first[7:1]` either equals `alt_addr[i]` or has `alt_mask[i]`=1.
- R5: With `gcall_en`=1, `rx_first[7:1]`=7'h00 is a general call hit.
- R6: With `smb_dev_en`=1, `rx_first[7:1]`=7'h61 hits. With `smb_alert_en`=1, 7'h0C hits. Each enable acts alone.
- R7: Among several hits the winner is primary, then secondary, then general call, then SMBus default device, then SMBus alert. `alt_hit` is 1 only when the secondary source wins, and `gcall_hit` only when general call wins.
- R8: With all five enables at 0, no strobe ever produces `match` or `ack`.
- R9: Results are captured at the clock edge that samples `cmp_strobe`=1 and hold unchanged until the next such edge. `alt_hit` and `gcall_hit` are recomputed on every compare.
- R10: `ack` is high for exactly the one cycle after a strobe that produced a match, and is 0 otherwise.
- R11: `match_addr` is `own_addr` for a 10-bit primary match. For every 7-bit match it is {3'b000, `rx_first[7:1]`}. With no match it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_strobe | input | 1 | One-cycle request to compare the received bytes |
| rx_first | input | 8 | First received byte: address in [7:1], read/write in [0] |
| rx_second | input | 8 | Second byte of a 10-bit address |
| own_addr | input | 10 | Primary own address |
| own_ten_bit | input | 1 | 1 selects 10-bit primary matching |
| own_en | input | 1 | Primary address enable |
| alt_addr | input | 7 | Secondary address |
| alt_mask | input | 7 | Secondary don't-care mask, 1 ignores the bit |
| alt_en | input | 1 | Secondary address enable |
| gcall_en | input | 1 | General call enable |
| smb_dev_en | input | 1 | SMBus default device address enable |
| smb_alert_en | input | 1 | SMBus alert response address enable |
| match | output | 1 | Last compare matched a source |
| ack | output | 1 | One-cycle acknowledge pulse |
| match_addr | output | 10 | Address that produced the match |
| alt_hit | output | 1 | Secondary source won the last compare |
| gcall_hit | output | 1 | General call won the last compare |

## Verification
The matcher keeps no state between compares except the captured result. Any wrong decision therefore appears on `match`, `match_addr` or the source flags in the very first cycle after the strobe that exposed it.

A mis-ordered priority or a sticky source flag only shows when two sources overlap on the same byte. The sweeps therefore place the primary and secondary addresses on top of the fixed addresses. A capture that leaks outside the strobe shows one cycle later, as outputs that move while the inputs change with the strobe low.

// File: rtl/i2c_amatch_pkg.sv
package i2c_amatch_pkg;

    localparam int OWN_W    = 10;
    localparam int SHORT_W  = 7;
    localparam int BYTE_W   = 8;
    localparam int PFX_W    = 5;
    localparam int HI_W     = OWN_W - BYTE_W;
    localparam int PAD_W    = OWN_W - SHORT_W;
    localparam int NUM_FIX  = 3;

    localparam logic [PFX_W-1:0]   TEN_PREFIX  = 5'b11110;
    localparam logic [SHORT_W-1:0] GCALL_ADDR  = 7'h00;
    localparam logic [SHORT_W-1:0] SMB_DEV     = 7'h61;
    localparam logic [SHORT_W-1:0] SMB_ALERT   = 7'h0C;

    // Reset values expected of the configuration register owner
    localparam logic OWN_EN_RST = 1'b1;
    localparam logic ALT_EN_RST = 1'b0;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_OWN   = 3'd1,
        SRC_ALT   = 3'd2,
        SRC_GCALL = 3'd3,
        SRC_DEV   = 3'd4,
        SRC_ALERT = 3'd5
    } src_e;

    typedef struct packed {
        logic             hit;
        logic [OWN_W-1:0] addr;
    } own_res_t;

    typedef struct packed {
        src_e             src;
        logic [OWN_W-1:0] addr;
    } result_t;

    // Fixed address table, index order is also priority order
    function automatic logic [SHORT_W-1:0] fixed_addr(input int idx);
        case (idx)
            0:       return GCALL_ADDR;
            1:       return SMB_DEV;
            default: return SMB_ALERT;
        endcase
    endfunction

    function automatic src_e fixed_src(input int idx);
        case (idx)
            0:       return SRC_GCALL;
            1:       return SRC_DEV;
            default: return SRC_ALERT;
        endcase
    endfunction

    function automatic logic [OWN_W-1:0] widen(input logic [SHORT_W-1:0] a);
        return {{PAD_W{1'b0}}, a};
    endfunction

endpackage

// File: rtl/i2c_amatch_own.sv
module i2c_amatch_own
    import i2c_amatch_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_first,
    input  logic [BYTE_W-1:0] rx_second,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              ten_bit,
    input  logic              enable,
    output own_res_t          res
);
    logic [SHORT_W-1:0] in7;
    logic               short_hit;
    logic               pfx_ok;
    logic               hi_ok;
    logic               lo_ok;
    logic               long_hit;

    assign in7       = rx_first[BYTE_W-1:1];
    assign short_hit = (in7 == own_addr[SHORT_W-1:0]);
    assign pfx_ok    = (rx_first[BYTE_W-1 -: PFX_W] == TEN_PREFIX);
    assign hi_ok     = (rx_first[HI_W:1] == own_addr[OWN_W-1 -: HI_W]);
    assign lo_ok     = (rx_second == own_addr[BYTE_W-1:0]);
    assign long_hit  = pfx_ok & hi_ok & lo_ok;

    always_comb begin
        res.hit  = enable & (ten_bit ? long_hit : short_hit);
        res.addr = ten_bit ? own_addr : widen(in7);
    end
endmodule

// File: rtl/i2c_amatch_alt.sv
module i2c_amatch_alt
    import i2c_amatch_pkg::*;
(
    input  logic [SHORT_W-1:0] in7,
    input  logic [SHORT_W-1:0] alt_addr,
    input  logic [SHORT_W-1:0] alt_mask,
    input  logic               enable,
    output logic               hit
);
    logic [SHORT_W-1:0] bit_ok;

    for (genvar i = 0; i < SHORT_W; i++) begin : g_bit
        assign bit_ok[i] = alt_mask[i] | (in7[i] ~^ alt_addr[i]);
    end

    assign hit = enable & (&bit_ok);
endmodule

// File: rtl/i2c_amatch_fixed.sv
module i2c_amatch_fixed
    import i2c_amatch_pkg::*;
#(
    parameter int NUM = NUM_FIX
) (
    input  logic [SHORT_W-1:0] in7,
    input  logic [NUM-1:0]     enables,
    output logic [NUM-1:0]     hits
);
    for (genvar k = 0; k < NUM; k++) begin : g_fix
        localparam logic [SHORT_W-1:0] CONST_ADDR = fixed_addr(k);
        assign hits[k] = enables[k] & (in7 == CONST_ADDR);
    end
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
    import i2c_amatch_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmp_strobe,
    input  logic [BYTE_W-1:0]  rx_first,
    input  logic [BYTE_W-1:0]  rx_second,
    input  logic [OWN_W-1:0]   own_addr,
    input  logic               own_ten_bit,
    input  logic               own_en,
    input  logic [SHORT_W-1:0] alt_addr,
    input  logic [SHORT_W-1:0] alt_mask,
    input  logic               alt_en,
    input  logic               gcall_en,
    input  logic               smb_dev_en,
    input  logic               smb_alert_en,
    output logic               match,
    output logic               ack,
    output logic [OWN_W-1:0]   match_addr,
    output logic               alt_hit,
    output logic               gcall_hit
);
    logic [SHORT_W-1:0] in7;
    logic               unused_rw;
    own_res_t           own_res;
    logic               alt_raw;
    logic [NUM_FIX-1:0] fix_en;
    logic [NUM_FIX-1:0] fix_hits;
    result_t            pick;
    result_t            held_q;
    logic               ack_q;
    logic               all_off;

    assign in7       = rx_first[BYTE_W-1:1];
    assign unused_rw = rx_first[0];
    assign fix_en    = {smb_alert_en, smb_dev_en, gcall_en};
    assign all_off   = ~(own_en | alt_en | gcall_en | smb_dev_en | smb_alert_en);

    i2c_amatch_own u_own (
        .rx_first  (rx_first),
        .rx_second (rx_second),
        .own_addr  (own_addr),
        .ten_bit   (own_ten_bit),
        .enable    (own_en),
        .res       (own_res)
    );

    i2c_amatch_alt u_alt (
        .in7      (in7),
        .alt_addr (alt_addr),
        .alt_mask (alt_mask),
        .enable   (alt_en),
        .hit      (alt_raw)
    );

    i2c_amatch_fixed #(.NUM(NUM_FIX)) u_fix (
        .in7     (in7),
        .enables (fix_en),
        .hits    (fix_hits)
    );

    // Priority: primary, secondary, then fixed table in index order
    always_comb begin
        pick.src  = SRC_NONE;
        pick.addr = '0;
        for (int k = NUM_FIX - 1; k >= 0; k--) begin
            if (fix_hits[k]) begin
                pick.src  = fixed_src(k);
                pick.addr = widen(in7);
            end
        end
        if (alt_raw) begin
            pick.src  = SRC_ALT;
            pick.addr = widen(in7);
        end
        if (own_res.hit) begin
            pick.src  = SRC_OWN;
            pick.addr = own_res.addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q.src  <= SRC_NONE;
            held_q.addr <= '0;
            ack_q       <= 1'b0;
        end else begin
            ack_q <= cmp_strobe & (pick.src != SRC_NONE);
            if (cmp_strobe) begin
                held_q <= pick;
            end
        end
    end

    assign match      = (held_q.src != SRC_NONE);
    assign ack        = ack_q;
    assign match_addr = held_q.addr;
    assign alt_hit    = (held_q.src == SRC_ALT);
    assign gcall_hit  = (held_q.src == SRC_GCALL);

    // R10
    ack_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(cmp_strobe));

    // R10
    ack_with_match_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> match);

    // R8
    all_off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_strobe && all_off) |=> (!match && !ack));

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_strobe |=> ($stable(match_addr) && $stable(match) && $stable(alt_hit)));

    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({alt_hit, gcall_hit}));

    // R11
    gcall_addr_chk: assert property (@(posedge clk) disable iff (rst)
        gcall_hit |-> (match_addr == widen(GCALL_ADDR)));

    // R3
    ten_bit_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_strobe && own_en && own_ten_bit && rx_first[7:3] != TEN_PREFIX
         && !alt_en && !gcall_en && !smb_dev_en && !smb_alert_en) |=> !match);
endmodule

// File: tb/i2c_tgt_addr_match_tb.sv
module i2c_tgt_addr_match_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmp_strobe;
    logic [7:0] rx_first, rx_second;
    logic [9:0] own_addr;
    logic       own_ten_bit, own_en;
    logic [6:0] alt_addr, alt_mask;
    logic       alt_en, gcall_en, smb_dev_en, smb_alert_en;
    logic       match, ack, alt_hit, gcall_hit;
    logic [9:0] match_addr;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    i2c_tgt_addr_match u_dut (
        .clk(clk), .rst(rst), .cmp_strobe(cmp_strobe),
        .rx_first(rx_first), .rx_second(rx_second),
        .own_addr(own_addr), .own_ten_bit(own_ten_bit), .own_en(own_en),
        .alt_addr(alt_addr), .alt_mask(alt_mask), .alt_en(alt_en),
        .gcall_en(gcall_en), .smb_dev_en(smb_dev_en), .smb_alert_en(smb_alert_en),
        .match(match), .ack(ack), .match_addr(match_addr),
        .alt_hit(alt_hit), .gcall_hit(gcall_hit)
    );

    // Expected outputs, packed as {match, alt_hit, gcall_hit, addr[9:0]}
    function automatic logic [12:0] model(input int f, input int s);
        int a7 = f / 2;
        bit p, q, g, d, r;
        if (own_ten_bit)
            p = own_en && (f / 8 == 30) && ((f / 2) % 4 == own_addr / 256)
                && (s == own_addr % 256);
        else
            p = own_en && (a7 == own_addr % 128);
        q = alt_en && ((((a7 ^ alt_addr) & ~alt_mask) & 127) == 0);
        g = gcall_en && (a7 == 0);
        d = smb_dev_en && (a7 == 97);
        r = smb_alert_en && (a7 == 12);
        if (p) return {3'b100, own_ten_bit ? own_addr : 10'(a7)};
        if (q) return {3'b110, 10'(a7)};
        if (g) return {3'b101, 10'(a7)};
        if (d || r) return {3'b100, 10'(a7)};
        return 13'd0;
    endfunction

    task automatic chk(input string req, input logic [13:0] got, input logic [13:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h (first=%h second=%h)", req, got, exp,
                     rx_first, rx_second);
        end
    endtask

    // One compare: strobe, check result and ack, then check hold with inputs moved
    task automatic compare(input int f, input int s, input string req);
        logic [12:0] e;
        @(negedge clk);
        rx_first = 8'(f); rx_second = 8'(s); cmp_strobe = 1'b1;
        e = model(f, s);
        @(negedge clk);
        cmp_strobe = 1'b0;
        // R10 ack pulse accompanies a match; R11 address; R7 flags
        chk(req, {ack, match, alt_hit, gcall_hit, match_addr},
            {e[12], e[12], e[11], e[10], e[9:0]});
        rx_first = ~rx_first; rx_second = ~rx_second;
        @(negedge clk);
        // R9 hold, R10 ack falls
        chk("R9", {ack, match, alt_hit, gcall_hit, match_addr},
            {1'b0, e[12], e[11], e[10], e[9:0]});
    endtask

    task automatic sweep7(input string req);
        for (int a = 0; a < 128; a++) compare(a * 2 + (a % 2), (a * 37) % 256, req);
    endtask

    task automatic set_cfg(input logic [9:0] oa, input logic ten, input logic oe,
                           input logic [6:0] aa, input logic [6:0] am, input logic ae,
                           input logic ge, input logic de, input logic re);
        own_addr = oa; own_ten_bit = ten; own_en = oe;
        alt_addr = aa; alt_mask = am; alt_en = ae;
        gcall_en = ge; smb_dev_en = de; smb_alert_en = re;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmp_strobe = 1'b0; rx_first = 8'h00; rx_second = 8'h00;
        set_cfg(10'h000, 1'b0, 1'b1, 7'h00, 7'h00, 1'b1, 1'b1, 1'b1, 1'b1);
        // R1: strobe during reset must not capture
        @(negedge clk); cmp_strobe = 1'b1;
        @(negedge clk); cmp_strobe = 1'b0;
        chk("R1", {ack, match, alt_hit, gcall_hit, match_addr}, 14'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1", {ack, match, alt_hit, gcall_hit, match_addr}, 14'd0);

        // R2 R4 R6: primary with junk top bits, masked secondary, all on
        set_cfg(10'h2B5, 1'b0, 1'b1, 7'h50, 7'h03, 1'b1, 1'b1, 1'b1, 1'b1);
        sweep7("R2/R4/R6");
        // R7: primary on general call, secondary on default device
        set_cfg(10'h000, 1'b0, 1'b1, 7'h61, 7'h00, 1'b1, 1'b1, 1'b1, 1'b1);
        sweep7("R7");
        // R7: secondary masked over general call and alert
        set_cfg(10'h000, 1'b0, 1'b0, 7'h08, 7'h0C, 1'b1, 1'b1, 1'b0, 1'b1);
        sweep7("R7/R4");
        // R8: everything off
        set_cfg(10'h2B5, 1'b0, 1'b0, 7'h00, 7'h7F, 1'b0, 1'b0, 1'b0, 1'b0);
        sweep7("R8");
        // R5 R6: fixed sources one at a time
        set_cfg(10'h000, 1'b0, 1'b0, 7'h00, 7'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        sweep7("R5");
        set_cfg(10'h000, 1'b0, 1'b0, 7'h00, 7'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        sweep7("R6");
        set_cfg(10'h000, 1'b0, 1'b0, 7'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        sweep7("R6");
        // R4 R9: alternate between secondary hit and miss, flag must clear
        set_cfg(10'h000, 1'b0, 1'b0, 7'h2A, 7'h10, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            compare(8'h54 | ((i % 2) * 8'h20), 0, "R4");
            compare(8'h02 * (i + 1), 0, "R9");
        end
        // R3 R11: 10-bit, every prefix byte against every second byte
        set_cfg(10'h2C7, 1'b1, 1'b1, 7'h00, 7'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int h = 0; h < 8; h++)
            for (int s = 0; s < 256; s++) compare(8'hF0 | h, s, "R3/R11");
        // R3: 7-bit compare against low bits must not hit in 10-bit mode
        for (int f = 0; f < 256; f++) compare(f, 8'hC7, "R3");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule